// File: doc/BRIEF.md
# Modem Status and Control with Loopback

This block keeps the modem-control and modem-status state of a 16550-style serial port. A byte-wide register bus writes the control register, which drives four modem output pins (data-terminal-ready, request-to-send and two general-purpose outputs) and carries the loopback enable. The status register shows four modem input lines (clear-to-send, data-set-ready, ring indicator, carrier detect) together with change bits for them.

In normal mode the four input lines are taken from the pins through a synchronizer. In loopback mode they are fed instead from the control register's own output bits, and the output pins are held inactive. Each line change sets a sticky change bit. The ring indicator is the exception: its change bit is set only when the line falls. A read of the status register clears every change bit. A modem-status-change flag, meant for interrupt logic, is high while any change bit is set.

Top module: `mstat_unit`

## Requirements
- R1: After reset the status register reads 0xB0 (DCD, DSR and CTS high, RI low, no change bits), the control register reads 0x08, `pin_out2` is 1, the other three pins are 0 and `stat_chg` is 0.
- R2: Control register bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is the loopback enable. Bits 7:5 read as zero. Outside loopback each pin follows its bit from the cycle after the write.
- R3: Status bits 7 (DCD), 6 (RI), 5 (DSR) and 4 (CTS) show the input pins `SYNC_STAGES+1` clock edges after the pins change.
- R4: Status bits 3 (DCD change), 1 (DSR change) and 0 (CTS change) are set when their line changes in either direction. They stay set through further changes until a status read.
- R5: Status bit 2 is set when RI goes from 1 to 0 and never when RI goes from 0 to 1.
- R6: A status read (`reg_rd` with `reg_sel`=1) returns the register value and clears bits 3:0 at that edge. A change that is detected at the same edge as the read is kept.
- R7: `stat_chg` is 1 exactly when any of status bits 3:0 is set.
- R8: In loopback the status lines take OUT2 as DCD, OUT1 as RI, RTS as CTS and DTR as DSR, one edge after the control register changes. These lines set change bits like the pins do.
- R9: In loopback all four output pins are 0, and changes on the input pins have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe (control register only) |
| reg_rd | input | 1 | Read strobe; clears change bits when status is selected |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data of the selected register |
| pin_cts | input | 1 | Clear-to-send input, active high |
| pin_dsr | input | 1 | Data-set-ready input, active high |
| pin_ri | input | 1 | Ring indicator input, active high |
| pin_dcd | input | 1 | Carrier detect input, active high |
| pin_dtr | output | 1 | Data-terminal-ready output |
| pin_rts | output | 1 | Request-to-send output |
| pin_out1 | output | 1 | General output 1 |
| pin_out2 | output | 1 | General output 2 |
| stat_chg | output | 1 | Any status change bit set |

## Verification
Two events can land on the same clock edge: the status read that clears the change bits, and a newly synchronized line change that sets one. The bench changes DSR while an older CTS change is still pending, and places the read strobe on the edge where the DSR change comes out of the synchronizer. The read must return the old CTS change, and the status read after it must show only the DSR change. The bench also steps the control register through several loopback values, including a fall on OUT1. This checks the remapping, the pin blanking and the rule that RI sets its change bit only on a fall.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
   localparam int LINE_N   = 4;
   // line index inside the status upper nibble and its change nibble
   localparam int LN_CTS   = 0;
   localparam int LN_DSR   = 1;
   localparam int LN_RI    = 2;
   localparam int LN_DCD   = 3;
   localparam logic [LINE_N-1:0] LINES_RESET = 4'b1011;

   localparam int CTRL_W   = 5;
   localparam int CB_DTR   = 0;
   localparam int CB_RTS   = 1;
   localparam int CB_OUT1  = 2;
   localparam int CB_OUT2  = 3;
   localparam int CB_LOOP  = 4;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 5'b01000;

   localparam logic SEL_CTRL = 1'b0;
   localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
   parameter int                 WIDTH  = 4,
   parameter int                 STAGES = 2,
   parameter logic [WIDTH-1:0]   INIT   = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 0) begin : g_bad_stages
      $error("mstat_sync: STAGES must not be negative");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (STAGES == 0) begin : g_pass
         assign q_out[b] = d_in[b];
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{INIT[b]}};
            else if (STAGES == 1) chain_q <= d_in[b];
            else chain_q <= {chain_q[STAGES-2:0], d_in[b]};
         end
         assign q_out[b] = chain_q[STAGES-1];
      end
   end
endmodule

// File: rtl/mstat_ctrl_reg.sv
module mstat_ctrl_reg
   import mstat_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              pin_dtr,
   output logic              pin_rts,
   output logic              pin_out1,
   output logic              pin_out2
);
   logic loop_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= CTRL_RESET;
      else if (wr_en) ctrl_q <= wdata[CTRL_W-1:0];
   end

   assign loop_on  = ctrl_q[CB_LOOP];
   assign pin_dtr  = ctrl_q[CB_DTR]  & ~loop_on;
   assign pin_rts  = ctrl_q[CB_RTS]  & ~loop_on;
   assign pin_out1 = ctrl_q[CB_OUT1] & ~loop_on;
   assign pin_out2 = ctrl_q[CB_OUT2] & ~loop_on;
endmodule

// File: rtl/mstat_line_tracker.sv
module mstat_line_tracker
   import mstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_N-1:0] line_src,
   input  logic              rd_clr,
   output logic [LINE_N-1:0] lines_q,
   output logic [LINE_N-1:0] delta_q
);
   logic [LINE_N-1:0] hit;

   // toggle detect per line; ring indicator only reports falls
   for (genvar i = 0; i < LINE_N; i++) begin : g_hit
      if (i == LN_RI) begin : g_fall
         assign hit[i] = lines_q[i] & ~line_src[i];
      end else begin : g_any
         assign hit[i] = lines_q[i] ^ line_src[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= LINES_RESET;
         delta_q <= '0;
      end else begin
         lines_q <= line_src;
         // new event outranks the clear so nothing is lost
         delta_q <= (rd_clr ? '0 : delta_q) | hit;
      end
   end
endmodule

// File: rtl/mstat_unit.sv
module mstat_unit
   import mstat_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_sel,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [BUS_W-1:0] reg_wdata,
   output logic [BUS_W-1:0] reg_rdata,
   input  logic             pin_cts,
   input  logic             pin_dsr,
   input  logic             pin_ri,
   input  logic             pin_dcd,
   output logic             pin_dtr,
   output logic             pin_rts,
   output logic             pin_out1,
   output logic             pin_out2,
   output logic             stat_chg
);
   localparam int STAT_W = 2 * LINE_N;

   if (BUS_W < STAT_W) begin : g_bad_bus
      $error("mstat_unit: BUS_W must hold the status byte");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [LINE_N-1:0] ext_raw, ext_sync, loop_lines, line_src;
   logic [LINE_N-1:0] lines_q, delta_q;
   logic [STAT_W-1:0] status;
   logic              rd_clr;

   assign ext_raw[LN_CTS] = pin_cts;
   assign ext_raw[LN_DSR] = pin_dsr;
   assign ext_raw[LN_RI]  = pin_ri;
   assign ext_raw[LN_DCD] = pin_dcd;

   mstat_sync #(.WIDTH(LINE_N), .STAGES(SYNC_STAGES), .INIT(LINES_RESET)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(ext_raw), .q_out(ext_sync));

   mstat_ctrl_reg #(.BUS_W(BUS_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && (reg_sel == SEL_CTRL)), .wdata(reg_wdata),
      .ctrl_q(ctrl_q),
      .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2));

   // loopback wiring of control outputs onto status inputs
   assign loop_lines[LN_CTS] = ctrl_q[CB_RTS];
   assign loop_lines[LN_DSR] = ctrl_q[CB_DTR];
   assign loop_lines[LN_RI]  = ctrl_q[CB_OUT1];
   assign loop_lines[LN_DCD] = ctrl_q[CB_OUT2];

   assign line_src = ctrl_q[CB_LOOP] ? loop_lines : ext_sync;
   assign rd_clr   = reg_rd && (reg_sel == SEL_STAT);

   mstat_line_tracker u_track (
      .clk(clk), .rst_n(rst_n), .line_src(line_src), .rd_clr(rd_clr),
      .lines_q(lines_q), .delta_q(delta_q));

   assign status    = {lines_q, delta_q};
   assign stat_chg  = |delta_q;
   assign reg_rdata = (reg_sel == SEL_STAT) ? BUS_W'(status) : BUS_W'(ctrl_q);
endmodule

// File: rtl/mstat_unit_chk.sv
module mstat_unit_chk
   import mstat_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_sel,
   input logic              reg_rd,
   input logic              pin_dtr,
   input logic              pin_rts,
   input logic              pin_out1,
   input logic              pin_out2,
   input logic              stat_chg,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [LINE_N-1:0] line_src,
   input logic [LINE_N-1:0] lines_q,
   input logic [LINE_N-1:0] delta_q
);
   logic rd_stat;
   assign rd_stat = reg_rd && (reg_sel == SEL_STAT);

   assert_pins_idle_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CB_LOOP] |-> !(pin_dtr || pin_rts || pin_out1 || pin_out2));

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && line_src == lines_q) |=> (delta_q == '0 && !stat_chg));

   assert_change_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (delta_q[LN_CTS] && !rd_stat) |=> delta_q[LN_CTS]);

   assert_ring_fall_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(delta_q[LN_RI]) |-> ($past(lines_q[LN_RI]) && !lines_q[LN_RI]));

   assert_loop_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q[CB_LOOP]) |->
         (lines_q == {$past(ctrl_q[CB_OUT2]), $past(ctrl_q[CB_OUT1]),
                      $past(ctrl_q[CB_DTR]), $past(ctrl_q[CB_RTS])}));

   assert_flag_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_chg) |-> ($past(line_src) != $past(lines_q)));
endmodule

bind mstat_unit mstat_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
   .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_out1(pin_out1), .pin_out2(pin_out2),
   .stat_chg(stat_chg), .ctrl_q(ctrl_q), .line_src(line_src),
   .lines_q(lines_q), .delta_q(delta_q));

// File: tb/tb_mstat_unit.sv
module tb_mstat_unit;
   localparam int CLK_PERIOD = 10;
   localparam int VEC_N = 8;
   // {pins as DCD,RI,DSR,CTS ; expected status}
   localparam logic [11:0] VEC [VEC_N] = '{
      {4'b1111, 8'hF0}, {4'b1011, 8'hB4}, {4'b0011, 8'h38}, {4'b1010, 8'hA9},
      {4'b1111, 8'hF1}, {4'b0000, 8'h0F}, {4'b0000, 8'h00}, {4'b1011, 8'hBB}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic pin_cts = 1'b1, pin_dsr = 1'b1, pin_ri = 1'b0, pin_dcd = 1'b1;
   logic pin_dtr, pin_rts, pin_out1, pin_out2, stat_chg;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mstat_unit dut (.*);

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic set_pins(input logic [3:0] v);
      {pin_dcd, pin_ri, pin_dsr, pin_cts} = v;
   endtask

   // called at a negedge, returns at the next negedge
   task automatic read_reg(input logic sel, input logic [7:0] exp, input string tag);
      reg_sel = sel; reg_rd = 1'b1;
      #1 check(tag, reg_rdata, exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic write_ctrl(input logic [7:0] v);
      reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   function automatic logic [7:0] pins();
      return {4'b0, pin_out2, pin_out1, pin_rts, pin_dtr};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 flag", {7'b0, stat_chg}, 8'h00);
      check("R1 pins", pins(), 8'h08);
      read_reg(1'b0, 8'h08, "R1 control");
      read_reg(1'b1, 8'hB0, "R1 status");

      // R3 R4 R5 R6 R7 table walk
      for (int i = 0; i < VEC_N; i++) begin
         set_pins(VEC[i][11:8]);
         repeat (4) @(negedge clk);
         check($sformatf("R7 flag vec%0d", i), {7'b0, stat_chg}, {7'b0, |VEC[i][3:0]});
         read_reg(1'b1, VEC[i][7:0], $sformatf("R3/R4/R5 vec%0d", i));
      end
      check("R6 flag after read", {7'b0, stat_chg}, 8'h00);

      // R4 accumulation across two toggles
      pin_cts = 1'b0; repeat (4) @(negedge clk);
      pin_cts = 1'b1; repeat (4) @(negedge clk);
      read_reg(1'b1, 8'hB1, "R4 sticky");
      read_reg(1'b1, 8'hB0, "R6 cleared");

      // R6 collision: read on the edge where a new change lands
      pin_cts = 1'b0; repeat (4) @(negedge clk);
      pin_dsr = 1'b0; repeat (2) @(negedge clk);
      read_reg(1'b1, 8'hA1, "R6 collision read");
      read_reg(1'b1, 8'h82, "R6 collision kept");
      set_pins(4'b1011); repeat (4) @(negedge clk);
      read_reg(1'b1, 8'hB3, "R4 restore");

      // R2 control fields
      write_ctrl(8'hE7);
      check("R2 pins", pins(), 8'h07);
      read_reg(1'b0, 8'h07, "R2 readback");

      // R8 R9 loopback
      write_ctrl(8'h1A);
      check("R9 pins idle", pins(), 8'h00);
      @(negedge clk);
      read_reg(1'b1, 8'h92, "R8 loop map");
      set_pins(4'b0000); repeat (4) @(negedge clk);
      read_reg(1'b1, 8'h90, "R9 pins ignored");
      write_ctrl(8'h15); @(negedge clk);
      read_reg(1'b1, 8'h6B, "R8 loop remap");
      write_ctrl(8'h11); @(negedge clk);
      read_reg(1'b1, 8'h24, "R5 loop ring fall");
      write_ctrl(8'h08); @(negedge clk);
      check("R2 pins after loop", pins(), 8'h08);
      read_reg(1'b1, 8'h02, "R8 exit loop");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule